// File: doc/BRIEF.md
# Virtual Function Error Report Queue

This block sits between a PCIe endpoint core and the application logic. The core runs on its own core clock. When a virtual function hits a non-fatal error, the core raises an event that says what kind of error it was and which VF and PF it belongs to. Each event slice has its own dual-clock queue. The block captures the event into that queue and moves it to the application control clock. There it appears for exactly one cycle, as a one-hot flag plus the VF and PF numbers. A wide build has two independent slices and a narrow build has one. If an event arrives while its queue is full, the event is lost. The block then raises a sticky overflow indication in the application domain, and software clears it with a pulse.

The application answers each error by sending a non-fatal message and then notifying this block. The block takes that notice through a ready/hold handshake. It keeps the VF and PF numbers of the notice and presents them to a shared message arbiter as a request. It accepts no further notice until the arbiter has granted the request.

Top module: `vf_err_report_q`

## Requirements
- R1: The 2-bit event kind selects the output flag: code 0 selects `rpt_poison_wr`, code 1 `rpt_poison_cpl`, code 2 `rpt_ur_posted` and code 3 `rpt_ca_posted`. While that flag is high, `rpt_vf` and `rpt_pf` of the same slice carry the VF and PF numbers given with the event, unchanged.
- R2: Each accepted event appears exactly once in the application domain, in the order it was accepted within its slice. At most one report per slice is presented per application clock, and every flag is a single-cycle pulse.
- R3: In each slice, at most one kind flag is high in any cycle. All four flags are low when that slice presents no report.
- R4: Each slice queues up to 2**DEPTH_LOG2 reports (16 by default). An event that arrives while its queue is full is dropped, and reports accepted before it are still delivered intact and in order.
- R5: After an event is dropped in any slice, `rpt_overflow` goes high in the application domain. It stays high until `ovf_clr` is sampled high, and it reads low in the cycle after that sample.
- R6: `rpt_overflow` stays low while no event has been dropped since the last clear or reset.
- R7: Slices are independent: simultaneous events on both slices are both delivered, and a full slice 0 does not affect slice 1. NUM_SLICES=1 builds only slice 0.
- R8: When `msg_sent` is high and `msg_ready` is high at an application clock edge, the notice is accepted. After that edge `msg_ready` is low, `arb_req` is high, and `arb_vf`/`arb_pf` hold the `msg_vf`/`msg_pf` values sampled at that edge.
- R9: While a notice is pending (`msg_ready` low), `msg_sent`, `msg_vf` and `msg_pf` are ignored. `arb_req`, `arb_vf` and `arb_pf` keep their values until a grant, and no second request follows from an ignored strobe.
- R10: The clock edge that samples `arb_gnt` high while `arb_req` is high drops `arb_req`, with `msg_ready` still low. `msg_ready` returns high one application clock later.
- R11: After reset, all report flags are low, `rpt_overflow` is low, `msg_ready` is high and `arb_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| core_clk | input | 1 | Core clock for event capture |
| core_rst_n | input | 1 | Active-low asynchronous reset, core domain |
| evt_vld | input | NUM_SLICES | Per-slice event strobe |
| evt_kind | input | 2*NUM_SLICES | Per-slice error kind code |
| evt_vf | input | 11*NUM_SLICES | Per-slice VF number |
| evt_pf | input | 3*NUM_SLICES | Per-slice PF number |
| app_clk | input | 1 | Application control clock |
| app_rst_n | input | 1 | Active-low asynchronous reset, application domain |
| rpt_poison_wr | output | NUM_SLICES | Poisoned write request received |
| rpt_poison_cpl | output | NUM_SLICES | Poisoned completion received |
| rpt_ur_posted | output | NUM_SLICES | Posted request answered with Unsupported Request |
| rpt_ca_posted | output | NUM_SLICES | Posted request answered with Completer Abort |
| rpt_vf | output | 11*NUM_SLICES | VF number of the presented report |
| rpt_pf | output | 3*NUM_SLICES | PF number of the presented report |
| rpt_overflow | output | 1 | Sticky lost-report indication |
| ovf_clr | input | 1 | Clears the overflow indication |
| msg_sent | input | 1 | Application has sent a non-fatal message |
| msg_vf | input | 11 | VF number of the sent message |
| msg_pf | input | 3 | PF number of the sent message |
| msg_ready | output | 1 | High when a new notice can be accepted |
| arb_req | output | 1 | Request toward the message arbiter |
| arb_vf | output | 11 | VF number held for the arbiter |
| arb_pf | output | 3 | PF number held for the arbiter |
| arb_gnt | input | 1 | Grant from the message arbiter |

## Verification
The assertions check on every cycle that the write pointer never runs more than one queue depth ahead of the synchronized read pointer, that the output flags stay one-hot and follow the queue's pop, that the overflow flag only falls on a clear, and the whole accept/hold/grant/ready sequence of the message handshake. Only the bench scenarios can show that data crosses the clock boundary with its kind, VF and PF intact and in order. They also show which events a full queue drops: the first sixteen of a burst must survive, and reports continue as an ordered subsequence. Finally, the scenarios show that the two slices stay independent while one of them overflows.

// File: rtl/vf_err_pkg.sv
package vf_err_pkg;

  localparam int KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    KIND_POISON_WR  = 2'b00,
    KIND_POISON_CPL = 2'b01,
    KIND_UR_POSTED  = 2'b10,
    KIND_CA_POSTED  = 2'b11
  } err_kind_e;

  typedef enum logic [1:0] {
    HS_IDLE = 2'b00,
    HS_PEND = 2'b01,
    HS_COOL = 2'b10
  } hs_state_e;

endpackage

// File: rtl/vf_err_rst_sync.sv
module vf_err_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/vf_err_afifo.sv
module vf_err_afifo #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_drop,
  input  logic          rclk,
  input  logic          rrst_n,
  output logic          rd_vld,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // write domain
  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d;
  logic [PW-1:0] rg_s1_q, rg_s2_q;
  logic          full, push;

  always_comb begin
    full    = (wgray_q == {~rg_s2_q[PW-1:PW-2], rg_s2_q[PW-3:0]});
    push    = wr_en & ~full;
    wr_drop = wr_en & full;
    wbin_d  = wbin_q + {{AW{1'b0}}, push};
    wgray_d = to_gray(wbin_d);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      rg_s1_q <= '0;
      rg_s2_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      rg_s1_q <= rgray_q;
      rg_s2_q <= rg_s1_q;
    end
  end

  always_ff @(posedge wclk) begin
    if (push) mem[wbin_q[AW-1:0]] <= wr_data;
  end

  // read domain
  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d;
  logic [PW-1:0] wg_s1_q, wg_s2_q;
  logic          empty, pop;
  logic          vld_d;
  logic [DW-1:0] data_d;

  always_comb begin
    empty   = (rgray_q == wg_s2_q);
    pop     = ~empty;
    rbin_d  = rbin_q + {{AW{1'b0}}, pop};
    rgray_d = to_gray(rbin_d);
    vld_d   = pop;
    data_d  = pop ? mem[rbin_q[AW-1:0]] : rd_data;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      wg_s1_q <= '0;
      wg_s2_q <= '0;
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      wg_s1_q <= wgray_q;
      wg_s2_q <= wg_s1_q;
      rd_vld  <= vld_d;
      rd_data <= data_d;
    end
  end

  // write pointer never more than one depth ahead of the observed reader (R4)
  logic [PW-1:0] rq_bin;
  assign rq_bin = from_gray(rg_s2_q);

  p_occupancy_bound_r4: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wbin_q - rq_bin) <= PW'(DEPTH));

endmodule

// File: rtl/vf_err_ovf_flag.sv
module vf_err_ovf_flag (
  input  logic wclk,
  input  logic wrst_n,
  input  logic drop,
  input  logic rclk,
  input  logic rrst_n,
  input  logic clr,
  output logic ovf
);

  // core side: toggle once per drop episode, wait for return acknowledge
  logic tog_q, tog_d, ack_s1_q, ack_s2_q, pending;

  always_comb begin
    pending = tog_q ^ ack_s2_q;
    tog_d   = (drop && !pending) ? ~tog_q : tog_q;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      tog_q    <= 1'b0;
      ack_s1_q <= 1'b0;
      ack_s2_q <= 1'b0;
    end else begin
      tog_q    <= tog_d;
      ack_s1_q <= seen_q;
      ack_s2_q <= ack_s1_q;
    end
  end

  // application side: detect toggle, set sticky flag
  logic t_s1_q, t_s2_q, seen_q, set_pulse, ovf_d;

  always_comb begin
    set_pulse = t_s2_q ^ seen_q;
    ovf_d     = set_pulse | (ovf & ~clr);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      t_s1_q <= 1'b0;
      t_s2_q <= 1'b0;
      seen_q <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      t_s1_q <= tog_q;
      t_s2_q <= t_s1_q;
      seen_q <= t_s2_q;
      ovf    <= ovf_d;
    end
  end

  p_sticky_r5: assert property (@(posedge rclk) disable iff (!rrst_n)
    (ovf && !clr) |=> ovf);

  p_clear_r5: assert property (@(posedge rclk) disable iff (!rrst_n)
    (ovf && clr && !set_pulse) |=> !ovf);

endmodule

// File: rtl/vf_err_msg_hs.sv
module vf_err_msg_hs
  import vf_err_pkg::*;
#(
  parameter int VF_W = 11,
  parameter int PF_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            msg_sent,
  input  logic [VF_W-1:0] msg_vf,
  input  logic [PF_W-1:0] msg_pf,
  output logic            msg_ready,
  output logic            arb_req,
  output logic [VF_W-1:0] arb_vf,
  output logic [PF_W-1:0] arb_pf,
  input  logic            arb_gnt
);

  hs_state_e       state_q, state_d;
  logic            cap_en;
  logic [VF_W-1:0] vf_d;
  logic [PF_W-1:0] pf_d;

  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    unique case (state_q)
      HS_IDLE: if (msg_sent) begin
        state_d = HS_PEND;
        cap_en  = 1'b1;
      end
      HS_PEND: if (arb_gnt) state_d = HS_COOL;
      HS_COOL: state_d = HS_IDLE;
      default: state_d = HS_IDLE;
    endcase
    vf_d = cap_en ? msg_vf : arb_vf;
    pf_d = cap_en ? msg_pf : arb_pf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      arb_vf  <= '0;
      arb_pf  <= '0;
    end else begin
      state_q <= state_d;
      arb_vf  <= vf_d;
      arb_pf  <= pf_d;
    end
  end

  assign msg_ready = (state_q == HS_IDLE);
  assign arb_req   = (state_q == HS_PEND);

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_sent && msg_ready) |=>
      (arb_req && !msg_ready && arb_vf == $past(msg_vf) && arb_pf == $past(msg_pf)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_req && !arb_gnt) |=> (arb_req && $stable(arb_vf) && $stable(arb_pf)));

  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_req && arb_gnt) |=> (!arb_req && !msg_ready));

  p_ready_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!arb_req && !msg_ready) |=> msg_ready);

endmodule

// File: rtl/vf_err_report_q.sv
module vf_err_report_q
  import vf_err_pkg::*;
#(
  parameter int NUM_SLICES = 2,
  parameter int VF_W       = 11,
  parameter int PF_W       = 3,
  parameter int DEPTH_LOG2 = 4
) (
  input  logic                       core_clk,
  input  logic                       core_rst_n,
  input  logic [NUM_SLICES-1:0]      evt_vld,
  input  logic [KIND_W*NUM_SLICES-1:0] evt_kind,
  input  logic [VF_W*NUM_SLICES-1:0] evt_vf,
  input  logic [PF_W*NUM_SLICES-1:0] evt_pf,
  input  logic                       app_clk,
  input  logic                       app_rst_n,
  output logic [NUM_SLICES-1:0]      rpt_poison_wr,
  output logic [NUM_SLICES-1:0]      rpt_poison_cpl,
  output logic [NUM_SLICES-1:0]      rpt_ur_posted,
  output logic [NUM_SLICES-1:0]      rpt_ca_posted,
  output logic [VF_W*NUM_SLICES-1:0] rpt_vf,
  output logic [PF_W*NUM_SLICES-1:0] rpt_pf,
  output logic                       rpt_overflow,
  input  logic                       ovf_clr,
  input  logic                       msg_sent,
  input  logic [VF_W-1:0]            msg_vf,
  input  logic [PF_W-1:0]            msg_pf,
  output logic                       msg_ready,
  output logic                       arb_req,
  output logic [VF_W-1:0]            arb_vf,
  output logic [PF_W-1:0]            arb_pf,
  input  logic                       arb_gnt
);

  localparam int DW = KIND_W + VF_W + PF_W;

  logic core_rst_ns, app_rst_ns;

  vf_err_rst_sync i_core_rst (.clk(core_clk), .arst_n(core_rst_n), .rst_n_sync(core_rst_ns));
  vf_err_rst_sync i_app_rst  (.clk(app_clk),  .arst_n(app_rst_n),  .rst_n_sync(app_rst_ns));

  logic [NUM_SLICES-1:0] slice_drop;

  for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
    logic          rd_vld;
    logic [DW-1:0] rd_data;
    err_kind_e     kind;
    logic [3:0]    flags;

    vf_err_afifo #(.DW(DW), .AW(DEPTH_LOG2)) i_fifo (
      .wclk    (core_clk),
      .wrst_n  (core_rst_ns),
      .wr_en   (evt_vld[g]),
      .wr_data ({evt_kind[KIND_W*g +: KIND_W], evt_vf[VF_W*g +: VF_W], evt_pf[PF_W*g +: PF_W]}),
      .wr_drop (slice_drop[g]),
      .rclk    (app_clk),
      .rrst_n  (app_rst_ns),
      .rd_vld  (rd_vld),
      .rd_data (rd_data)
    );

    always_comb begin
      kind  = err_kind_e'(rd_data[DW-1 -: KIND_W]);
      flags = '0;
      if (rd_vld) begin
        unique case (kind)
          KIND_POISON_WR:  flags[0] = 1'b1;
          KIND_POISON_CPL: flags[1] = 1'b1;
          KIND_UR_POSTED:  flags[2] = 1'b1;
          KIND_CA_POSTED:  flags[3] = 1'b1;
          default:         flags    = '0;
        endcase
      end
    end

    assign rpt_poison_wr[g]          = flags[0];
    assign rpt_poison_cpl[g]         = flags[1];
    assign rpt_ur_posted[g]          = flags[2];
    assign rpt_ca_posted[g]          = flags[3];
    assign rpt_vf[VF_W*g +: VF_W]    = rd_data[PF_W +: VF_W];
    assign rpt_pf[PF_W*g +: PF_W]    = rd_data[PF_W-1:0];

    p_flags_track_pop_r3: assert property (@(posedge app_clk) disable iff (!app_rst_ns)
      $onehot0(flags) && ((|flags) == rd_vld));
  end

  vf_err_ovf_flag i_ovf (
    .wclk   (core_clk),
    .wrst_n (core_rst_ns),
    .drop   (|slice_drop),
    .rclk   (app_clk),
    .rrst_n (app_rst_ns),
    .clr    (ovf_clr),
    .ovf    (rpt_overflow)
  );

  vf_err_msg_hs #(.VF_W(VF_W), .PF_W(PF_W)) i_msg (
    .clk       (app_clk),
    .rst_n     (app_rst_ns),
    .msg_sent  (msg_sent),
    .msg_vf    (msg_vf),
    .msg_pf    (msg_pf),
    .msg_ready (msg_ready),
    .arb_req   (arb_req),
    .arb_vf    (arb_vf),
    .arb_pf    (arb_pf),
    .arb_gnt   (arb_gnt)
  );

endmodule

// File: tb/test_vf_err_report_q.sv
module test_vf_err_report_q;

  localparam int NS = 2;
  localparam int VW = 11;
  localparam int PW = 3;

  logic core_clk = 1'b0;
  logic app_clk  = 1'b0;
  always #7  core_clk = ~core_clk;
  always #10 app_clk  = ~app_clk;

  logic              core_rst_n, app_rst_n;
  logic [NS-1:0]     evt_vld;
  logic [2*NS-1:0]   evt_kind;
  logic [VW*NS-1:0]  evt_vf;
  logic [PW*NS-1:0]  evt_pf;
  logic [NS-1:0]     rpt_poison_wr, rpt_poison_cpl, rpt_ur_posted, rpt_ca_posted;
  logic [VW*NS-1:0]  rpt_vf;
  logic [PW*NS-1:0]  rpt_pf;
  logic              rpt_overflow, ovf_clr;
  logic              msg_sent, msg_ready, arb_req, arb_gnt;
  logic [VW-1:0]     msg_vf, arb_vf;
  logic [PW-1:0]     msg_pf, arb_pf;

  vf_err_report_q #(.NUM_SLICES(NS)) i_vf_err_report_q (
    .core_clk(core_clk), .core_rst_n(core_rst_n),
    .evt_vld(evt_vld), .evt_kind(evt_kind), .evt_vf(evt_vf), .evt_pf(evt_pf),
    .app_clk(app_clk), .app_rst_n(app_rst_n),
    .rpt_poison_wr(rpt_poison_wr), .rpt_poison_cpl(rpt_poison_cpl),
    .rpt_ur_posted(rpt_ur_posted), .rpt_ca_posted(rpt_ca_posted),
    .rpt_vf(rpt_vf), .rpt_pf(rpt_pf),
    .rpt_overflow(rpt_overflow), .ovf_clr(ovf_clr),
    .msg_sent(msg_sent), .msg_vf(msg_vf), .msg_pf(msg_pf), .msg_ready(msg_ready),
    .arb_req(arb_req), .arb_vf(arb_vf), .arb_pf(arb_pf), .arb_gnt(arb_gnt)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  bit lossy0 = 0;
  int lossy_rx = 0;
  logic [15:0] q0[$];
  logic [15:0] q1[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pk(input int k, input int vf, input int pf);
    return {k[1:0], vf[10:0], pf[2:0]};
  endfunction

  // driver: one core cycle per call, expected item queued in scoreboard
  task automatic evt(input bit e0, input logic [15:0] d0, input bit e1, input logic [15:0] d1);
    @(negedge core_clk);
    evt_vld  = {e1, e0};
    evt_kind = {d1[15:14], d0[15:14]};
    evt_vf   = {d1[13:3], d0[13:3]};
    evt_pf   = {d1[2:0], d0[2:0]};
    if (e0) q0.push_back(d0);
    if (e1) q1.push_back(d1);
  endtask

  task automatic evt_idle();
    @(negedge core_clk);
    evt_vld = '0;
  endtask

  task automatic take(input int s, input logic [15:0] got);
    logic [15:0] exp;
    int skipped;
    if (s == 0 && lossy0) begin
      skipped = 0;
      while (q0.size() > 0 && q0[0] != got) begin
        void'(q0.pop_front());
        skipped++;
      end
      if (q0.size() == 0) chk(0, "R4 report not in sent order", got, 0);
      else begin
        void'(q0.pop_front());
        chk(skipped == 0 || lossy_rx >= 16, "R4 early report lost", lossy_rx, 16);
        lossy_rx++;
      end
    end else begin
      if ((s == 0 ? q0.size() : q1.size()) == 0) chk(0, "R2 unexpected report", got, 0);
      else begin
        exp = (s == 0) ? q0.pop_front() : q1.pop_front();
        chk(got == exp, "R1 R2 report content/order", got, exp);
      end
    end
  endtask

  // monitor
  always @(negedge app_clk) begin
    if (app_rst_n) begin
      for (int s = 0; s < NS; s++) begin
        logic [3:0] f;
        logic [1:0] k;
        f = {rpt_ca_posted[s], rpt_ur_posted[s], rpt_poison_cpl[s], rpt_poison_wr[s]};
        if (f != 4'b0000) begin
          if (!$onehot(f)) chk(0, "R3 multiple flags", f, 0);
          k = f[1] ? 2'd1 : f[2] ? 2'd2 : f[3] ? 2'd3 : 2'd0;
          take(s, {k, rpt_vf[s*VW +: VW], rpt_pf[s*PW +: PW]});
        end
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge app_clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R2: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    core_rst_n = 0; app_rst_n = 0;
    evt_vld = '0; evt_kind = '0; evt_vf = '0; evt_pf = '0;
    ovf_clr = 0; msg_sent = 0; msg_vf = '0; msg_pf = '0; arb_gnt = 0;
    repeat (5) @(negedge app_clk);
    core_rst_n = 1; app_rst_n = 1;
    repeat (4) @(negedge app_clk);

    // R11 reset state
    chk({rpt_poison_wr, rpt_poison_cpl, rpt_ur_posted, rpt_ca_posted} == '0, "R11 flags", 1, 0);
    chk(rpt_overflow == 0, "R11 overflow", rpt_overflow, 0);
    chk(msg_ready == 1, "R11 ready", msg_ready, 1);
    chk(arb_req == 0, "R11 req", arb_req, 0);

    // R1 every kind, extreme identifiers
    evt(1, pk(0, 5, 1), 0, '0);
    evt(1, pk(1, 11'h7FF, 7), 0, '0);
    evt(1, pk(2, 0, 0), 0, '0);
    evt(1, pk(3, 300, 4), 0, '0);
    evt_idle();

    // R7 both slices at once
    for (int i = 0; i < 8; i++)
      evt(1, pk(i % 4, i * 3, i % 8), 1, pk((i + 1) % 4, 1000 + i, (7 - i) % 8));
    evt_idle();

    // R2 back-to-back on slice 1
    for (int i = 0; i < 12; i++) evt(0, '0, 1, pk(i % 4, i + 50, i % 8));
    evt_idle();

    repeat (60) @(negedge app_clk);
    chk(q0.size() == 0, "R2 slice0 all delivered", q0.size(), 0);
    chk(q1.size() == 0, "R2 slice1 all delivered", q1.size(), 0);
    chk(rpt_overflow == 0, "R6 no overflow", rpt_overflow, 0);

    // R4 R5 overflow burst on slice 0, light traffic on slice 1
    lossy0 = 1;
    lossy_rx = 0;
    for (int i = 0; i < 100; i++) evt(1, pk(i % 4, i, i % 8), i < 10, pk(3, i + 200, 2));
    evt_idle();
    repeat (100) @(negedge app_clk);
    lossy0 = 0;
    chk(lossy_rx >= 16, "R4 queue depth delivered", lossy_rx, 16);
    chk(lossy_rx < 100, "R4 drop on full", lossy_rx, 99);
    q0.delete();
    chk(q1.size() == 0, "R7 slice1 unaffected", q1.size(), 0);
    chk(rpt_overflow == 1, "R5 overflow set", rpt_overflow, 1);
    repeat (10) @(negedge app_clk);
    chk(rpt_overflow == 1, "R5 overflow sticky", rpt_overflow, 1);

    @(negedge app_clk) ovf_clr = 1;
    @(negedge app_clk) ovf_clr = 0;
    chk(rpt_overflow == 0, "R5 overflow cleared", rpt_overflow, 0);

    evt(1, pk(2, 77, 3), 0, '0);
    evt(1, pk(1, 78, 6), 0, '0);
    evt_idle();
    repeat (30) @(negedge app_clk);
    chk(q0.size() == 0, "R2 post-clear delivered", q0.size(), 0);
    chk(rpt_overflow == 0, "R6 stays low", rpt_overflow, 0);

    // R8 accept
    @(negedge app_clk);
    msg_sent = 1; msg_vf = 11'h123; msg_pf = 3'd5;
    @(negedge app_clk);
    msg_sent = 0;
    chk(msg_ready == 0, "R8 ready low", msg_ready, 0);
    chk(arb_req == 1, "R8 req high", arb_req, 1);
    chk(arb_vf == 11'h123, "R8 vf", arb_vf, 11'h123);
    chk(arb_pf == 3'd5, "R8 pf", arb_pf, 5);

    // R9 ignored strobe while pending
    msg_sent = 1; msg_vf = 11'h456; msg_pf = 3'd2;
    @(negedge app_clk);
    msg_sent = 0;
    repeat (3) @(negedge app_clk);
    chk(arb_req == 1, "R9 req held", arb_req, 1);
    chk(arb_vf == 11'h123, "R9 vf held", arb_vf, 11'h123);
    chk(arb_pf == 3'd5, "R9 pf held", arb_pf, 5);
    chk(msg_ready == 0, "R9 ready low", msg_ready, 0);

    // R10 grant
    arb_gnt = 1;
    @(negedge app_clk);
    arb_gnt = 0;
    chk(arb_req == 0, "R10 req dropped", arb_req, 0);
    chk(msg_ready == 0, "R10 ready still low", msg_ready, 0);
    @(negedge app_clk);
    chk(msg_ready == 1, "R10 ready back", msg_ready, 1);
    chk(arb_req == 0, "R9 no request from ignored strobe", arb_req, 0);

    // R8 R10 second notice, granted at once
    msg_sent = 1; msg_vf = 11'h7FF; msg_pf = 3'd7;
    @(negedge app_clk);
    msg_sent = 0;
    chk(arb_vf == 11'h7FF, "R8 second vf", arb_vf, 11'h7FF);
    chk(arb_req == 1, "R8 second req", arb_req, 1);
    arb_gnt = 1;
    @(negedge app_clk);
    arb_gnt = 0;
    chk(arb_req == 0, "R10 immediate grant", arb_req, 0);
    @(negedge app_clk);
    chk(msg_ready == 1, "R10 ready after immediate grant", msg_ready, 1);

    done = 1;
    summary();
    $finish;
  end

endmodule